// File: doc/BRIEF.md
# APB Countdown Timer

A single-channel timer peripheral reached through an APB slave port. Once enabled, it loads its counter from a programmable load register and counts down by one on every peripheral clock. When the counter has reached zero, the next clock is an expiry. On an expiry the counter reloads, either from the load register (periodic mode) or with all ones (free-running mode), and a raw interrupt flag is set. Software measures elapsed time by inverting the current-value register.

The interrupt output is the raw flag gated by a mask bit in the control register. Reading either of two clear registers, one beside the channel registers and one in the global group, drops the flag. An expiry in the same cycle as such a read wins, so no event is lost. The global group also reports the masked and raw flags and a fixed version word.

The counter is a two-state machine. In `ST_HALT` the count is held. The transition `HALT->RUN` happens when enable is seen set, and it loads the counter from the load register. In `ST_RUN` the machine takes one of three transitions. `RUN->RUN decrement` happens while the count is non-zero. `RUN->RUN expiry` reloads the counter and pulses the expiry event. `RUN->HALT` happens when enable is seen cleared, and it keeps the count.

Top module: `apb_countdown_timer`

## Requirements
- R1: After reset, all registers read zero apart from the version word (0xAC), and `irq_o` is low.
- R2: Enable is control bit 0 (control at 0x08, load at 0x00, current value at 0x04). When enable goes from 0 to 1, the counter is loaded from the load register one clock after the write. It then decreases by one each clock.
- R3: Control bit 1 is the mode bit. When it is 0 (free-running), the clock after the counter reaches zero reloads it with 0xFFFF_FFFF.
- R4: When control bit 1 is 1 (periodic), the clock after the counter reaches zero reloads it with the load register value.
- R5: Each expiry sets the raw flag. A read of 0x0C returns zero and clears the flag.
- R6: Control bit 2 is the mask bit. `irq_o`, bit 0 of 0x10 and bit 0 of 0xA0 all equal raw AND NOT mask. Bit 0 of 0xA8 is the raw flag, whatever the mask.
- R7: Clearing enable stops the counter within one clock, and the counter then holds its value. A load written while disabled takes effect only at the next enable.
- R8: A read of 0xA4 clears the raw flag in the same way as 0x0C.
- R9: 0xAC returns the VERSION parameter. Unmapped offsets read zero. Writes to read-only offsets change nothing.
- R10: If a clear read and an expiry fall in the same cycle, the raw flag stays set.
- R11: `pready` is always 1 and `pslverr` always 0. Control reads back only bits [2:0], and its upper bits read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pclk | input | 1 | Peripheral clock, also the count clock |
| presetn | input | 1 | Active-low asynchronous reset |
| psel | input | 1 | APB select |
| penable | input | 1 | APB access phase |
| pwrite | input | 1 | APB write when high |
| paddr | input | ADDR_W | APB byte address |
| pwdata | input | DATA_W | APB write data |
| prdata | output | DATA_W | APB read data |
| pready | output | 1 | Always ready |
| pslverr | output | 1 | Always no error |
| irq_o | output | 1 | Masked interrupt |

## Verification
The bench times a clear read so that its access edge lands exactly on an expiry. A design that let the clear win would drop the flag and lose that event. Periodic mode with a load of zero expires on every clock. A counter that underflowed, or that reloaded one cycle late, would then show a non-zero count or gaps in the interrupt. The bench also checks that a load written while halted leaves the held count alone until the next enable. It further checks that a write to the current-value register changes nothing and that a masked expiry still shows in the raw register. A design that loaded the counter at write time, or that gated the raw flag with the mask, would fail these checks.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

    localparam logic [7:0] OFS_LOAD   = 8'h00;
    localparam logic [7:0] OFS_CURR   = 8'h04;
    localparam logic [7:0] OFS_CTRL   = 8'h08;
    localparam logic [7:0] OFS_CLR    = 8'h0C;
    localparam logic [7:0] OFS_STAT   = 8'h10;
    localparam logic [7:0] OFS_GSTAT  = 8'hA0;
    localparam logic [7:0] OFS_GCLR   = 8'hA4;
    localparam logic [7:0] OFS_GRAW   = 8'hA8;
    localparam logic [7:0] OFS_VER    = 8'hAC;

    localparam int CTRL_BITS = 3;

    typedef enum logic [0:0] {
        ST_HALT = 1'b0,
        ST_RUN  = 1'b1
    } run_state_e;

    typedef struct packed {
        logic mask;
        logic periodic;
        logic enable;
    } ctrl_t;

endpackage

// File: rtl/tmr_apb_regs.sv
module tmr_apb_regs
    import tmr_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_stb,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] load_q,
    output ctrl_t             ctrl_q
);

    logic hit_load;
    logic hit_ctrl;

    always_comb begin
        hit_load = wr_stb && (addr == ADDR_W'(OFS_LOAD));
        hit_ctrl = wr_stb && (addr == ADDR_W'(OFS_CTRL));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            load_q <= '0;
        end else if (hit_load) begin
            load_q <= wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q <= '0;
        end else if (hit_ctrl) begin
            ctrl_q <= ctrl_t'(wdata[CTRL_BITS-1:0]);
        end
    end

endmodule

// File: rtl/tmr_count_fsm.sv
module tmr_count_fsm
    import tmr_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  ctrl_t             ctrl,
    input  logic [DATA_W-1:0] load,
    output logic [DATA_W-1:0] cnt_q,
    output run_state_e        state_q,
    output logic              expire
);

    localparam logic [DATA_W-1:0] ALL_ONES = '1;
    localparam logic [DATA_W-1:0] ONE      = DATA_W'(1);

    run_state_e        state_d;
    logic [DATA_W-1:0] cnt_d;

    // state and count register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_HALT;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    // transitions and outputs
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        expire  = 1'b0;
        unique case (state_q)
            ST_HALT: begin
                if (ctrl.enable) begin
                    state_d = ST_RUN;
                    cnt_d   = load;
                end
            end
            ST_RUN: begin
                if (!ctrl.enable) begin
                    state_d = ST_HALT;
                end else if (cnt_q == '0) begin
                    expire = 1'b1;
                    cnt_d  = ctrl.periodic ? load : ALL_ONES;
                end else begin
                    cnt_d = cnt_q - ONE;
                end
            end
            default: begin
                state_d = ST_HALT;
            end
        endcase
    end

endmodule

// File: rtl/tmr_irq_stat.sv
module tmr_irq_stat (
    input  logic clk,
    input  logic rst_n,
    input  logic expire,
    input  logic clr,
    output logic raw_q
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            raw_q <= 1'b0;
        end else if (expire) begin
            raw_q <= 1'b1;
        end else if (clr) begin
            raw_q <= 1'b0;
        end
    end

endmodule

// File: rtl/tmr_read_mux.sv
module tmr_read_mux
    import tmr_pkg::*;
#(
    parameter int          DATA_W  = 32,
    parameter int          ADDR_W  = 8,
    parameter logic [31:0] VERSION = 32'h0102_0304
) (
    input  logic              rd_sel,
    input  logic              rd_acc,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] load,
    input  logic [DATA_W-1:0] cnt,
    input  ctrl_t             ctrl,
    input  logic              raw,
    output logic [DATA_W-1:0] rdata,
    output logic              clr
);

    logic masked;

    always_comb begin
        masked = raw && !ctrl.mask;
        clr    = rd_acc && ((addr == ADDR_W'(OFS_CLR)) ||
                            (addr == ADDR_W'(OFS_GCLR)));
        rdata  = '0;
        if (rd_sel) begin
            unique case (addr)
                ADDR_W'(OFS_LOAD):  rdata = load;
                ADDR_W'(OFS_CURR):  rdata = cnt;
                ADDR_W'(OFS_CTRL):  rdata = DATA_W'(ctrl);
                ADDR_W'(OFS_STAT):  rdata = DATA_W'(masked);
                ADDR_W'(OFS_GSTAT): rdata = DATA_W'(masked);
                ADDR_W'(OFS_GRAW):  rdata = DATA_W'(raw);
                ADDR_W'(OFS_VER):   rdata = DATA_W'(VERSION);
                default:            rdata = '0;
            endcase
        end
    end

endmodule

// File: rtl/apb_countdown_timer.sv
module apb_countdown_timer
    import tmr_pkg::*;
#(
    parameter int          DATA_W  = 32,
    parameter int          ADDR_W  = 8,
    parameter logic [31:0] VERSION = 32'h3230_312A
) (
    input  logic              pclk,
    input  logic              presetn,
    input  logic              psel,
    input  logic              penable,
    input  logic              pwrite,
    input  logic [ADDR_W-1:0] paddr,
    input  logic [DATA_W-1:0] pwdata,
    output logic [DATA_W-1:0] prdata,
    output logic              pready,
    output logic              pslverr,
    output logic              irq_o
);

    logic              wr_stb;
    logic              rd_sel;
    logic              rd_acc;
    logic [DATA_W-1:0] load_w;
    logic [DATA_W-1:0] cnt_w;
    ctrl_t             ctrl_w;
    run_state_e        state_w;
    logic              expire_w;
    logic              raw_w;
    logic              clr_w;

    always_comb begin
        wr_stb  = psel && penable && pwrite;
        rd_sel  = psel && !pwrite;
        rd_acc  = psel && penable && !pwrite;
        pready  = 1'b1;
        pslverr = 1'b0;
        irq_o   = raw_w && !ctrl_w.mask;
    end

    tmr_apb_regs #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_regs (
        .clk    (pclk),
        .rst_n  (presetn),
        .wr_stb (wr_stb),
        .addr   (paddr),
        .wdata  (pwdata),
        .load_q (load_w),
        .ctrl_q (ctrl_w)
    );

    tmr_count_fsm #(.DATA_W(DATA_W)) u_fsm (
        .clk     (pclk),
        .rst_n   (presetn),
        .ctrl    (ctrl_w),
        .load    (load_w),
        .cnt_q   (cnt_w),
        .state_q (state_w),
        .expire  (expire_w)
    );

    tmr_irq_stat u_irq (
        .clk    (pclk),
        .rst_n  (presetn),
        .expire (expire_w),
        .clr    (clr_w),
        .raw_q  (raw_w)
    );

    tmr_read_mux #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .VERSION(VERSION)) u_rmux (
        .rd_sel (rd_sel),
        .rd_acc (rd_acc),
        .addr   (paddr),
        .load   (load_w),
        .cnt    (cnt_w),
        .ctrl   (ctrl_w),
        .raw    (raw_w),
        .rdata  (prdata),
        .clr    (clr_w)
    );

endmodule

// File: rtl/tmr_chk.sv
module tmr_chk
    import tmr_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 8
) (
    input logic              pclk,
    input logic              presetn,
    input logic              psel,
    input logic              penable,
    input logic              pwrite,
    input logic [ADDR_W-1:0] paddr,
    input logic              pready,
    input logic              pslverr,
    input logic              irq_o,
    input ctrl_t             ctrl,
    input logic [DATA_W-1:0] load,
    input logic [DATA_W-1:0] cnt,
    input run_state_e        state,
    input logic              raw
);

    logic zero_hit;
    logic clr_c;
    logic clr_g;

    always_comb begin
        zero_hit = (state == ST_RUN) && ctrl.enable && (cnt == '0);
        clr_c    = psel && penable && !pwrite && (paddr == ADDR_W'(OFS_CLR));
        clr_g    = psel && penable && !pwrite && (paddr == ADDR_W'(OFS_GCLR));
    end

    AST_APB_NO_WAIT: assert property (@(posedge pclk) disable iff (!presetn)
        pready && !pslverr); // R11
    AST_ENABLE_LOAD: assert property (@(posedge pclk) disable iff (!presetn)
        (state == ST_HALT && ctrl.enable) |=> (cnt == $past(load))); // R2
    AST_FREE_WRAP: assert property (@(posedge pclk) disable iff (!presetn)
        (zero_hit && !ctrl.periodic) |=> (cnt == '1)); // R3
    AST_PERIOD_RELOAD: assert property (@(posedge pclk) disable iff (!presetn)
        (zero_hit && ctrl.periodic) |=> (cnt == $past(load))); // R4
    AST_EXPIRY_SETS_RAW: assert property (@(posedge pclk) disable iff (!presetn)
        zero_hit |=> raw); // R5
    AST_LOCAL_CLEAR: assert property (@(posedge pclk) disable iff (!presetn)
        (clr_c && !zero_hit) |=> !raw); // R5
    AST_MASK_GATES_IRQ: assert property (@(posedge pclk) disable iff (!presetn)
        ctrl.mask |-> !irq_o); // R6
    AST_HALT_HOLDS: assert property (@(posedge pclk) disable iff (!presetn)
        (state == ST_HALT && !ctrl.enable) |=> $stable(cnt)); // R7
    AST_GLOBAL_CLEAR: assert property (@(posedge pclk) disable iff (!presetn)
        (clr_g && !zero_hit) |=> !raw); // R8
    AST_CLEAR_LOSES: assert property (@(posedge pclk) disable iff (!presetn)
        ((clr_c || clr_g) && zero_hit) |=> raw); // R10

endmodule

bind apb_countdown_timer tmr_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
    .pclk    (pclk),
    .presetn (presetn),
    .psel    (psel),
    .penable (penable),
    .pwrite  (pwrite),
    .paddr   (paddr),
    .pready  (pready),
    .pslverr (pslverr),
    .irq_o   (irq_o),
    .ctrl    (ctrl_w),
    .load    (load_w),
    .cnt     (cnt_w),
    .state   (state_w),
    .raw     (raw_w)
);

// File: tb/tb_apb_countdown_timer.sv
`timescale 1ns/1ps
module tb_apb_countdown_timer;

    localparam logic [31:0] VER = 32'h3230_312A;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
    logic [7:0]  paddr = '0;
    logic [31:0] pwdata = '0;
    logic [31:0] prdata;
    logic        pready, pslverr, irq_o;

    int n_checks = 0;
    int n_fail = 0;
    bit done = 0;

    always #2 clk = ~clk;

    apb_countdown_timer #(.DATA_W(32), .ADDR_W(8), .VERSION(VER)) dut (
        .pclk(clk), .presetn(rst_n), .psel(psel), .penable(penable),
        .pwrite(pwrite), .paddr(paddr), .pwdata(pwdata), .prdata(prdata),
        .pready(pready), .pslverr(pslverr), .irq_o(irq_o)
    );

    // behavioural reference model
    logic [31:0] m_load, m_cnt;
    bit m_en, m_mode, m_mask, m_run, m_raw;

    always @(posedge clk) begin
        bit acc_w, acc_r, hit;
        logic [31:0] nc;
        bit nr;
        if (!rst_n) begin
            m_load = 0; m_cnt = 0; m_en = 0; m_mode = 0; m_mask = 0;
            m_run = 0; m_raw = 0;
        end else begin
            acc_w = psel && penable && pwrite;
            acc_r = psel && penable && !pwrite;
            hit = 0; nc = m_cnt; nr = m_run;
            if (!m_run) begin
                if (m_en) begin nc = m_load; nr = 1; end
            end else if (!m_en) begin
                nr = 0;
            end else if (m_cnt == 0) begin
                hit = 1;
                nc = m_mode ? m_load : 32'hFFFF_FFFF;
            end else begin
                nc = m_cnt - 1;
            end
            m_raw = hit || (m_raw && !(acc_r && (paddr == 8'h0C || paddr == 8'hA4)));
            m_cnt = nc; m_run = nr;
            if (acc_w && paddr == 8'h00) m_load = pwdata;
            if (acc_w && paddr == 8'h08) {m_mask, m_mode, m_en} = pwdata[2:0];
        end
    end

    function automatic logic [31:0] exp_rd(input logic [7:0] a);
        case (a)
            8'h00: return m_load;
            8'h04: return m_cnt;
            8'h08: return {29'd0, m_mask, m_mode, m_en};
            8'h10, 8'hA0: return {31'd0, m_raw && !m_mask};
            8'hA8: return {31'd0, m_raw};
            8'hAC: return VER;
            default: return 32'd0;
        endcase
    endfunction

    // per-clock comparison of the interrupt line, R6
    always @(negedge clk) begin
        if (rst_n && !done) begin
            n_checks++;
            if (irq_o !== (m_raw && !m_mask)) begin
                n_fail++;
                $display("FAIL R6 irq_o actual=%0b expected=%0b at %0t",
                         irq_o, m_raw && !m_mask, $time);
            end
        end
    end

    task automatic apb_wr(input logic [7:0] a, input logic [31:0] d);
        psel = 1; pwrite = 1; paddr = a; pwdata = d; penable = 0;
        @(negedge clk);
        penable = 1;
        @(negedge clk);
        psel = 0; penable = 0; pwrite = 0;
    endtask

    task automatic apb_rd(input logic [7:0] a, input string tag);
        logic [31:0] e;
        psel = 1; pwrite = 0; paddr = a; penable = 0;
        @(negedge clk);
        penable = 1;
        #1;
        e = exp_rd(a);
        n_checks++;
        if (prdata !== e) begin
            n_fail++;
            $display("FAIL %s read 0x%02h actual=0x%08h expected=0x%08h", tag, a, prdata, e);
        end
        n_checks++;
        if (pready !== 1'b1 || pslverr !== 1'b0) begin
            n_fail++;
            $display("FAIL R11 pready/pslverr actual=%0b/%0b expected=1/0", pready, pslverr);
        end
        @(negedge clk);
        psel = 0; penable = 0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wait_cnt_one();
        while (!(m_run && m_en && m_cnt == 1)) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1 reset state
        apb_rd(8'h00, "R1"); apb_rd(8'h04, "R1"); apb_rd(8'h08, "R1");
        apb_rd(8'h10, "R1"); apb_rd(8'hA0, "R1"); apb_rd(8'hA8, "R1");
        // R9 version and unmapped
        apb_rd(8'hAC, "R9"); apb_rd(8'h14, "R9"); apb_rd(8'h50, "R9");
        // R2/R4 periodic count
        apb_wr(8'h00, 32'd5);
        apb_wr(8'h08, 32'h3);
        apb_rd(8'h04, "R2"); apb_rd(8'h04, "R2");
        idle(6);
        apb_rd(8'h04, "R4"); apb_rd(8'hA8, "R5"); apb_rd(8'h10, "R6");
        apb_rd(8'h0C, "R5"); apb_rd(8'hA8, "R5");
        // R10 clear read on the expiry edge
        wait_cnt_one();
        apb_rd(8'h0C, "R10");
        apb_rd(8'hA8, "R10");
        apb_rd(8'hA4, "R8"); apb_rd(8'hA8, "R8");
        // R6 masked expiry
        apb_wr(8'h08, 32'h7);
        idle(8);
        apb_rd(8'hA8, "R6"); apb_rd(8'hA0, "R6"); apb_rd(8'h10, "R6");
        // R7 halt and hold, load while halted
        apb_wr(8'h08, 32'h6);
        apb_rd(8'h04, "R7"); idle(3); apb_rd(8'h04, "R7");
        apb_wr(8'h00, 32'd9);
        apb_rd(8'h04, "R7");
        // R9 read-only write ignored
        apb_wr(8'h04, 32'hDEAD_BEEF);
        apb_wr(8'hA8, 32'h1);
        apb_rd(8'h04, "R9"); apb_rd(8'hA8, "R9");
        // R3 free running with enable loading 9
        apb_wr(8'h08, 32'hFFFF_FFF9);
        apb_rd(8'h08, "R11");
        apb_rd(8'h04, "R2");
        idle(10);
        apb_rd(8'h04, "R3"); apb_rd(8'hA4, "R8");
        // R10 periodic load zero: expiry every clock
        apb_wr(8'h08, 32'h0);
        apb_wr(8'h00, 32'd0);
        apb_wr(8'h08, 32'h3);
        idle(2);
        apb_rd(8'h04, "R4"); apb_rd(8'h0C, "R10"); apb_rd(8'hA8, "R10");
        idle(2);
        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_checks++; n_fail++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end

endmodule